// File: doc/BRIEF.md
# Byte-Wide Register File for a Two-Phase 6502-Family Bus

This block is a slave register file for a processor bus of the 6502 family. It is the first piece of a larger input/output controller. The processor side presents the PHI2 phase clock, a read/write strobe, an active-low select and an address. The block holds a bank of byte registers. A write is taken when PHI2 falls. Read data leaves on its own output bus, together with an enable flag. Because reads and writes use separate buses, the design needs no bidirectional net.

The block runs on a fast system clock and treats PHI2 as a sampled input. It detects the falling transition of PHI2 internally and commits a write once for each bus cycle. The read output is enabled only during the PHI2-high phase. This keeps the data lines free during the low phase, when a 16-bit-capable processor places its bank byte on them.

The block decodes only the low address bits, so the register window mirrors across the whole range that the select covers. Two register slots are also brought out directly as a port value and its direction mask.

Top module: `bus_regfile`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every register is cleared to 0x00. After reset, every address reads 0x00, and `port_val` and `port_dir` are 0x00.
- R2: A write happens on the first rising `clk` edge at which `phi2` is sampled low, provided it was sampled high on the previous edge and `cs_n`=0 and `rw`=0 at that moment. The value on `wdata` is stored in the register addressed by `addr`, and it is visible from the following cycle onward.
- R3: A falling PHI2 edge with `cs_n`=1, or with `rw`=1 (a read), leaves every register unchanged. Clock cycles without a falling PHI2 edge also leave every register unchanged.
- R4: `rdata_oe` is 1 exactly when `phi2`=1, `cs_n`=0 and `rw`=1. It stays 0 through the PHI2-low phase of a read cycle.
- R5: When `rdata_oe`=1, `rdata` equals the addressed register. When `rdata_oe`=0, `rdata` is 0x00.
- R6: Only `addr[3:0]` selects one of the sixteen registers. Addresses that differ only in `addr[7:4]` reach the same register.
- R7: If `rst` is high on the same edge as a qualifying write, the reset wins and the register reads 0x00 afterwards.
- R8: `port_val` always equals register 0, and `port_dir` always equals register 1 (1 = output bit).
- R9: Holding `phi2` low for several clocks while `wdata` changes does not rewrite the register. Only the value present at the falling edge is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than PHI2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled |
| rw | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 8 | Bus address, only the low 4 bits decoded |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data, 0x00 when not enabled |
| rdata_oe | output | 1 | Read output enable |
| port_val | output | 8 | Contents of register 0 |
| port_dir | output | 8 | Contents of register 1, direction mask |

## Verification
The bench aims at the phase edges. It checks that output enable stays low through the PHI2-low half of a read. A design gated only by select and strobe would drive the bus during the bank-byte phase. It holds PHI2 low while changing the write data, which exposes a level-sensitive capture that takes the last value instead of the edge value. It also drives mirrored high address bits, which catch a decoder that compares too many bits. Finally, it lines up reset with a write edge, which catches a bank that gives the write priority.

// File: rtl/bus_regfile_pkg.sv
package bus_regfile_pkg;

    localparam int DEF_DATA_W   = 8;
    localparam int DEF_IDX_W    = 4;
    localparam int DEF_BUS_AW   = 8;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic      hi;
        logic      fell;
    } phase_t;

    function automatic acc_kind_e classify(input logic sel_n, input logic rd_wr_n);
        if (sel_n)
            return ACC_NONE;
        else if (rd_wr_n)
            return ACC_READ;
        else
            return ACC_WRITE;
    endfunction

endpackage

// File: rtl/phi2_tracker.sv
module phi2_tracker
    import bus_regfile_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   phi2,
    output phase_t phase
);
    logic phi2_q;

    always_ff @(posedge clk) begin
        if (rst)
            phi2_q <= 1'b0;
        else
            phi2_q <= phi2;
    end

    always_comb begin
        phase.hi   = phi2;
        phase.fell = phi2_q & ~phi2;
    end
endmodule

// File: rtl/bus_decode.sv
module bus_decode
    import bus_regfile_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W,
    localparam int NREG = 1 << IDX_W
) (
    input  phase_t           phase,
    input  logic             cs_n,
    input  logic             rw,
    input  logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  wr_sel,
    output logic             rd_en
);
    acc_kind_e kind;

    assign kind  = classify(cs_n, rw);
    assign rd_en = phase.hi && (kind == ACC_READ);

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wr_sel[g] = phase.fell && (kind == ACC_WRITE) && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import bus_regfile_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NREG   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREG-1:0]             wr_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NREG-1:0][DATA_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_sel[g])
                regs[g] <= wdata;
        end
    end
endmodule

// File: rtl/read_mux.sv
module read_mux
    import bus_regfile_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int IDX_W  = DEF_IDX_W,
    localparam int NREG  = 1 << IDX_W
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        rd_en,
    output logic [DATA_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = regs[idx];
    end
endmodule

// File: rtl/bus_regfile.sv
module bus_regfile
    import bus_regfile_pkg::*;
#(
    parameter int DATA_W         = DEF_DATA_W,
    parameter int IDX_W          = DEF_IDX_W,
    parameter int BUS_AW         = DEF_BUS_AW,
    parameter int PORT_DATA_SLOT = 0,
    parameter int PORT_DIR_SLOT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              rw,
    input  logic              cs_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic [DATA_W-1:0] port_val,
    output logic [DATA_W-1:0] port_dir
);
    localparam int NREG = 1 << IDX_W;

    phase_t                      phase;
    logic [IDX_W-1:0]            idx;
    logic [NREG-1:0]             wr_sel;
    logic                        rd_en;
    logic [NREG-1:0][DATA_W-1:0] regs;

    // upper bus address lines are not decoded: the window mirrors
    if (BUS_AW > IDX_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr[BUS_AW-1:IDX_W];
    end
    assign idx = addr[IDX_W-1:0];

    phi2_tracker u_phase (
        .clk   (clk),
        .rst   (rst),
        .phi2  (phi2),
        .phase (phase)
    );

    bus_decode #(.IDX_W(IDX_W)) u_dec (
        .phase  (phase),
        .cs_n   (cs_n),
        .rw     (rw),
        .idx    (idx),
        .wr_sel (wr_sel),
        .rd_en  (rd_en)
    );

    reg_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (wr_sel),
        .wdata  (wdata),
        .regs   (regs)
    );

    read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rmux (
        .regs  (regs),
        .idx   (idx),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    assign rdata_oe = rd_en;
    assign port_val = regs[PORT_DATA_SLOT];
    assign port_dir = regs[PORT_DIR_SLOT];
endmodule

// File: rtl/bus_regfile_chk.sv
module bus_regfile_chk #(
    parameter int DATA_W         = 8,
    parameter int IDX_W          = 4,
    parameter int BUS_AW         = 8,
    parameter int PORT_DATA_SLOT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              phi2,
    input logic              rw,
    input logic              cs_n,
    input logic [BUS_AW-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic [DATA_W-1:0] port_val,
    input logic [DATA_W-1:0] port_dir
);
    logic phi2_seen;
    logic wr_event;

    always_ff @(posedge clk) begin
        if (rst)
            phi2_seen <= 1'b0;
        else
            phi2_seen <= phi2;
    end

    assign wr_event = phi2_seen && !phi2 && !cs_n && !rw;

    assert_oe_gated_R4: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (phi2 && !cs_n && rw));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (port_val == '0 && port_dir == '0));

    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_event |=> ($stable(port_val) && $stable(port_dir)));

    assert_port_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && addr[IDX_W-1:0] == IDX_W'(PORT_DATA_SLOT)) |-> (rdata == port_val));
endmodule

bind bus_regfile bus_regfile_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .BUS_AW(BUS_AW), .PORT_DATA_SLOT(PORT_DATA_SLOT)
) u_chk (
    .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .cs_n(cs_n), .addr(addr),
    .rdata(rdata), .rdata_oe(rdata_oe), .port_val(port_val), .port_dir(port_dir)
);

// File: tb/sim_bus_regfile.sv
module sim_bus_regfile;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phi2 = 1'b0;
    logic       rw = 1'b1;
    logic       cs_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] port_val;
    logic [7:0] port_dir;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_regfile u0 (
        .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .cs_n(cs_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .port_val(port_val), .port_dir(port_dir)
    );

    // behavioural reference model, updated every clock
    int unsigned mdl [16];
    bit          mdl_phi_prev;
    always @(posedge clk) begin
        if (rst) begin
            foreach (mdl[i]) mdl[i] <= 0;
            mdl_phi_prev <= 0;
        end else begin
            if (mdl_phi_prev && !phi2 && !cs_n && !rw)
                mdl[addr % 16] <= wdata;
            mdl_phi_prev <= phi2;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit          e_oe;
            int unsigned e_rd;
            e_oe = phi2 && !cs_n && rw;
            e_rd = e_oe ? mdl[addr % 16] : 0;
            check(rdata_oe == e_oe, "R4 oe", rdata_oe, e_oe);
            check(rdata == e_rd,    "R5 rdata", rdata, e_rd);
            check(port_val == mdl[0] && port_dir == mdl[1], "R8 port", {port_dir, port_val}, {mdl[1][7:0], mdl[0][7:0]});
        end
    end

    // one processor bus cycle
    task automatic bus_cycle(input bit is_wr, input bit sel, input logic [7:0] a,
                             input logic [7:0] d, output logic [7:0] got,
                             output bit got_oe, output bit low_oe);
        @(negedge clk); #1;
        phi2 = 0; cs_n = !sel; rw = !is_wr; addr = a; wdata = is_wr ? d : ~d;
        @(negedge clk); low_oe = rdata_oe;
        #1 phi2 = 1;
        repeat (2) @(negedge clk);
        got = rdata; got_oe = rdata_oe;
        #1 phi2 = 0;
        @(negedge clk); #1;
        cs_n = 1; rw = 1;
        @(negedge clk);
    endtask

    logic [7:0] exp_mem [16];
    logic [7:0] g;
    bit         goe, loe;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 8'h17);
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        check(port_val == 0 && port_dir == 0, "R1 reset ports", {port_dir, port_val}, 0);
        for (int i = 0; i < 16; i++) begin
            bus_cycle(0, 1, 8'(i), 8'h00, g, goe, loe);
            check(g == 8'h00, "R1 reset read", g, 0);
        end

        // R2: write distinct values everywhere, then read back
        for (int i = 0; i < 16; i++) begin
            exp_mem[i] = pat(i);
            bus_cycle(1, 1, 8'(i), exp_mem[i], g, goe, loe);
            check(goe == 0, "R4 no oe on write", goe, 0);
        end
        for (int i = 0; i < 16; i++) begin
            bus_cycle(0, 1, 8'(i), 8'h00, g, goe, loe);
            check(g == exp_mem[i], "R2 readback", g, exp_mem[i]);
            check(goe == 1, "R4 oe in phi2 high", goe, 1);
            check(loe == 0, "R4 oe low in phi2 low", loe, 0);
        end

        // R8: port outputs follow slots 0 and 1
        check(port_val == exp_mem[0], "R8 port_val", port_val, exp_mem[0]);
        check(port_dir == exp_mem[1], "R8 port_dir", port_dir, exp_mem[1]);

        // R6: mirrored addresses
        for (int i = 0; i < 16; i += 5) begin
            bus_cycle(0, 1, 8'(i) | 8'hA0, 8'h00, g, goe, loe);
            check(g == exp_mem[i], "R6 mirror read", g, exp_mem[i]);
        end
        bus_cycle(1, 1, 8'h73, 8'hC4, g, goe, loe);
        exp_mem[3] = 8'hC4;
        bus_cycle(0, 1, 8'h03, 8'h00, g, goe, loe);
        check(g == 8'hC4, "R6 mirror write", g, 8'hC4);

        // R3/R5: unselected cycles are ignored and leave the bus idle
        bus_cycle(1, 0, 8'h03, 8'hEE, g, goe, loe);
        bus_cycle(0, 0, 8'h03, 8'h00, g, goe, loe);
        check(goe == 0 && g == 0, "R5 unselected idle", {goe, g}, 0);
        bus_cycle(0, 1, 8'h03, 8'h00, g, goe, loe);
        check(g == 8'hC4, "R3 unselected write ignored", g, 8'hC4);
        // R3: a read cycle does not modify (wdata carries junk)
        bus_cycle(0, 1, 8'h05, 8'h00, g, goe, loe);
        bus_cycle(0, 1, 8'h05, 8'h00, g, goe, loe);
        check(g == exp_mem[5], "R3 read no modify", g, exp_mem[5]);

        // R9: long phi2-low phase with changing data keeps the edge value
        @(negedge clk); #1;
        phi2 = 0; cs_n = 0; rw = 0; addr = 8'h09; wdata = 8'h3C;
        @(negedge clk); #1 phi2 = 1;
        repeat (2) @(negedge clk);
        #1 phi2 = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1 wdata = 8'h80 + 8'(k);
        end
        @(negedge clk); #1 cs_n = 1; rw = 1;
        bus_cycle(0, 1, 8'h09, 8'h00, g, goe, loe);
        check(g == 8'h3C, "R9 single capture", g, 8'h3C);

        // R7: reset on the same edge as a write
        @(negedge clk); #1;
        phi2 = 0; cs_n = 0; rw = 0; addr = 8'h0B; wdata = 8'h99;
        @(negedge clk); #1 phi2 = 1;
        repeat (2) @(negedge clk);
        #1 phi2 = 0; rst = 1;
        @(negedge clk); #1 rst = 0; cs_n = 1; rw = 1;
        @(negedge clk);
        bus_cycle(0, 1, 8'h0B, 8'h00, g, goe, loe);
        check(g == 8'h00, "R7 reset beats write", g, 0);
        check(port_val == 0 && port_dir == 0, "R1 ports after reset", {port_dir, port_val}, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule